// File: doc/BRIEF.md
# Two-wire serial memory byte master

This block drives a two-wire serial bus toward an external memory, one byte or one bus condition per command. A host loads an outgoing byte into the data register and then writes a command code into the low nibble of the control register. The block shifts the byte out, samples the acknowledge bit that comes back, and records it in a status bit. A receive command clocks eight bits in from the device and leaves them in the data register. Depending on the code, the block answers that byte with an acknowledge or leaves the acknowledge slot released. Separate codes produce start and stop conditions.

The serial clock runs only while an operation is active and rests high at all other times. The data line is open-drain: the block only ever pulls it low or lets it go. Each bus bit lasts four quarter periods, and the quarter length is derived from the system clock frequency and the bit rate, which defaults to 78 kHz. The host either polls the busy bit or waits for the one-cycle interrupt pulse that follows the end of every operation.

Top module: `serial_prom_master`

## Requirements
- R1: After reset, and after a reset that cuts an operation short, the status port reads 0x30, the data port reads 0x00, `scl` is 1, `sda_oe` is 0 and `irq` is 0.
- R2: Command code 3 sends the data register MSB first. Each bit is sampled on a rising `scl`, and `sda` never changes while `scl` is high during a byte. `sda_oe`=1 pulls the line low. The data register keeps the sent byte.
- R3: After a code 3 transfer, status bit 5 holds the sampled acknowledge level: 0 when the device pulled the line low in the ninth clock, 1 otherwise.
- R4: Codes 4 and 5 shift eight bits in MSB first, sampled on rising `scl`, into the data register. Code 4 pulls the ninth bit low and clears status bit 4. Code 5 leaves the ninth bit released and sets status bit 4.
- R5: Code 1 makes `sda` fall while `scl` is high (start). Code 2 makes `sda` rise while `scl` is high (stop). Both end with `scl` high.
- R6: Status bit 6 (busy) reads 1 from the cycle after an accepted command until the operation ends. `scl` is 1 whenever busy is 0.
- R7: `irq` pulses high for exactly one cycle, in the cycle after busy falls, once per completed operation.
- R8: A code other than 1 to 5 sets status bit 7 (error) and starts nothing. The next accepted command clears error. Status bits 3:0 hold the code of the last accepted command.
- R9: While busy is 1, a control write is ignored and sets error, and a data write leaves the data register unchanged.
- R10: One `scl` period lasts CLK_HZ/BIT_HZ system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 1 | Write strobe for the data register |
| wr_ctrl | input | 1 | Write strobe for the control register (command in bits 3:0) |
| wdata | input | 8 | Write data for either register |
| data_q | output | 8 | Data register contents |
| stat_q | output | 8 | {error, busy, rx-ack-n, tx-ack-n, last code} |
| scl | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_in | input | 1 | Level sensed on the data line |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach are control and data writes that land in the middle of a running transfer. The rejected command must not disturb the byte on the wire, and the data write must not overwrite the register. The bench gets there with a table entry that fires both writes twenty cycles into a transmit. It then checks the captured byte, the data register and the sticky error bit after completion. A device model on the bench answers each clock edge by edge-count, so acknowledge, no-acknowledge and the host-driven ninth bit are all produced and observed at the pins.

// File: rtl/spm_pkg.sv
package spm_pkg;

  localparam logic [3:0] CODE_START    = 4'h1;
  localparam logic [3:0] CODE_STOP     = 4'h2;
  localparam logic [3:0] CODE_SEND     = 4'h3;
  localparam logic [3:0] CODE_RECV_ACK = 4'h4;
  localparam logic [3:0] CODE_RECV_NAK = 4'h5;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_START,
    SEQ_STOP,
    SEQ_BIT,
    SEQ_TAIL
  } seq_e;

  typedef struct packed {
    logic       err;
    logic       busy;
    logic       rx_ack_n;
    logic       tx_ack_n;
    logic [3:0] code;
  } stat_t;

  function automatic logic code_legal(input logic [3:0] c);
    return (c >= CODE_START) && (c <= CODE_RECV_NAK);
  endfunction

  function automatic logic code_is_recv(input logic [3:0] c);
    return (c == CODE_RECV_ACK) || (c == CODE_RECV_NAK);
  endfunction

endpackage

// File: rtl/spm_qtick.sv
module spm_qtick #(
  parameter int QTR = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/spm_sync.sv
module spm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff <= '1;
    end else begin
      ff <= {ff[STAGES-2:0], d};
    end
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/spm_engine.sv
module spm_engine
  import spm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [3:0]    code,
  input  logic [DW-1:0] tx_byte,
  input  logic          tick,
  input  logic          sda_s,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          ack_n,
  output logic          scl_o,
  output logic          sda_oe_o
);
  localparam int BW = $clog2(DW + 1);
  localparam logic [BW-1:0] ACK_SLOT = BW'(DW);

  seq_e          seq, nseq;
  logic [1:0]    q, nq;
  logic [BW-1:0] bitn, nbit;
  logic [DW-1:0] sh;
  logic [3:0]    code_q, ncode;
  logic          last_q;
  logic [1:0]    drv;

  function automatic logic [1:0] drive(
    input seq_e          s,
    input logic [1:0]    qq,
    input logic [BW-1:0] bn,
    input logic          dbit,
    input logic [3:0]    cd,
    input logic          oe_now
  );
    logic val;
    case (s)
      SEQ_START: case (qq)
        2'd0:    return {1'b0, oe_now};
        2'd1:    return 2'b00;
        2'd2:    return 2'b10;
        default: return 2'b11;
      endcase
      SEQ_STOP: case (qq)
        2'd0:    return {1'b0, oe_now};
        2'd1:    return 2'b01;
        2'd2:    return 2'b11;
        default: return 2'b10;
      endcase
      SEQ_BIT: begin
        if (bn == ACK_SLOT) val = (cd == CODE_RECV_ACK);
        else                val = (cd == CODE_SEND) ? ~dbit : 1'b0;
        return {qq[1], (qq == 2'd1) ? val : oe_now};
      end
      SEQ_TAIL:  return (qq == 2'd0) ? {1'b0, oe_now} : 2'b00;
      default:   return {1'b1, oe_now};
    endcase
  endfunction

  always_comb begin
    case (seq)
      SEQ_TAIL: last_q = (q == 2'd1);
      SEQ_IDLE: last_q = 1'b0;
      default:  last_q = (q == 2'd3);
    endcase
  end

  always_comb begin
    nseq  = seq;
    nq    = q;
    nbit  = bitn;
    ncode = code_q;
    if (seq == SEQ_IDLE) begin
      if (go) begin
        ncode = code;
        nq    = 2'd0;
        nbit  = '0;
        if (code == CODE_START)     nseq = SEQ_START;
        else if (code == CODE_STOP) nseq = SEQ_STOP;
        else                        nseq = SEQ_BIT;
      end
    end else if (tick) begin
      if (!last_q) begin
        nq = q + 2'd1;
      end else begin
        nq = 2'd0;
        if (seq == SEQ_BIT) begin
          if (bitn == ACK_SLOT) nseq = SEQ_TAIL;
          else                  nbit = bitn + 1'b1;
        end else begin
          nseq = SEQ_IDLE;
        end
      end
    end
  end

  assign drv = drive(nseq, nq, nbit, sh[DW-1], ncode, sda_oe_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq      <= SEQ_IDLE;
      q        <= 2'd0;
      bitn     <= '0;
      code_q   <= '0;
      sh       <= '0;
      ack_n    <= 1'b1;
      scl_o    <= 1'b1;
      sda_oe_o <= 1'b0;
    end else begin
      seq      <= nseq;
      q        <= nq;
      bitn     <= nbit;
      code_q   <= ncode;
      scl_o    <= drv[1];
      sda_oe_o <= drv[0];
      if (seq == SEQ_IDLE && go) begin
        sh <= tx_byte;
      end else if (tick && seq == SEQ_BIT && q == 2'd2) begin
        if (bitn == ACK_SLOT) ack_n <= sda_s;
        else                  sh    <= {sh[DW-2:0], sda_s};
      end
    end
  end

  assign busy    = (seq != SEQ_IDLE);
  assign done    = tick && last_q && (seq != SEQ_BIT);
  assign rx_byte = sh;
endmodule

// File: rtl/spm_regs.sv
module spm_regs
  import spm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_data,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          eng_busy,
  input  logic          eng_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          ack_n,
  output logic          go,
  output logic [3:0]    go_code,
  output logic [DW-1:0] data_q,
  output stat_t         stat,
  output logic          irq
);
  logic       err_q, rx_ack_q, tx_ack_q, busy_d;
  logic [3:0] code_q;

  assign go_code = wdata[3:0];
  assign go      = wr_ctrl && !eng_busy && code_legal(go_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      err_q    <= 1'b0;
      rx_ack_q <= 1'b1;
      tx_ack_q <= 1'b1;
      code_q   <= '0;
      busy_d   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      busy_d <= eng_busy;
      irq    <= busy_d && !eng_busy;
      if (wr_data && !eng_busy) data_q <= wdata;
      if (eng_done) begin
        if (code_is_recv(code_q)) begin
          data_q   <= rx_byte;
          tx_ack_q <= (code_q == CODE_RECV_NAK);
        end
        if (code_q == CODE_SEND) rx_ack_q <= ack_n;
      end
      if (wr_ctrl) begin
        if (go) begin
          err_q  <= 1'b0;
          code_q <= go_code;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign stat = '{err: err_q, busy: eng_busy, rx_ack_n: rx_ack_q,
                  tx_ack_n: tx_ack_q, code: code_q};
endmodule

// File: rtl/serial_prom_master.sv
module serial_prom_master
  import spm_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BIT_HZ      = 78_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_data,
  input  logic       wr_ctrl,
  input  logic [7:0] wdata,
  output logic [7:0] data_q,
  output logic [7:0] stat_q,
  output logic       scl,
  output logic       sda_oe,
  input  logic       sda_in,
  output logic       irq
);
  localparam int DW  = 8;
  localparam int QTR = CLK_HZ / (4 * BIT_HZ);

  logic          tick, sda_s, go, eng_busy, eng_done, ack_n;
  logic [3:0]    go_code;
  logic [DW-1:0] rx_byte;
  stat_t         stat;

  spm_qtick #(.QTR(QTR)) u_tick (
    .clk(clk), .rst(rst), .run(eng_busy), .tick(tick)
  );

  spm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
  );

  spm_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .go(go), .code(go_code), .tx_byte(data_q),
    .tick(tick), .sda_s(sda_s), .busy(eng_busy), .done(eng_done),
    .rx_byte(rx_byte), .ack_n(ack_n), .scl_o(scl), .sda_oe_o(sda_oe)
  );

  spm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .wdata(wdata), .eng_busy(eng_busy), .eng_done(eng_done),
    .rx_byte(rx_byte), .ack_n(ack_n), .go(go), .go_code(go_code),
    .data_q(data_q), .stat(stat), .irq(irq)
  );

  assign stat_q = stat;
endmodule

// File: rtl/serial_prom_master_chk.sv
module serial_prom_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_data,
  input logic       wr_ctrl,
  input logic [7:0] wdata,
  input logic [7:0] data_q,
  input logic [7:0] stat_q,
  input logic       scl,
  input logic       sda_oe,
  input logic       irq
);
  logic legal;
  assign legal = spm_pkg::code_legal(wdata[3:0]);

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_q == 8'h30 && data_q == 8'h00 && scl && !sda_oe && !irq));

  p_accept_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !stat_q[6] && legal) |=> stat_q[6]);

  p_idle_scl_high_r6: assert property (@(posedge clk) disable iff (rst)
    !stat_q[6] |-> scl);

  p_irq_after_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_q[6]) |=> irq);

  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_illegal_err_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !stat_q[6] && !legal) |=> (stat_q[7] && !stat_q[6]));

  p_busy_cmd_err_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && stat_q[6]) |=> stat_q[7]);

  p_busy_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_data && stat_q[6]) |=> ((data_q == $past(data_q)) || !stat_q[6]));
endmodule

bind serial_prom_master serial_prom_master_chk u_chk (
  .clk(clk), .rst(rst), .wr_data(wr_data), .wr_ctrl(wr_ctrl), .wdata(wdata),
  .data_q(data_q), .stat_q(stat_q), .scl(scl), .sda_oe(sda_oe), .irq(irq)
);

// File: tb/serial_prom_master_test.sv
module serial_prom_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_248_000;
  localparam int BIT_HZ     = 78_000;
  localparam int BIT_CYC    = CLK_HZ / BIT_HZ;

  typedef struct packed {
    logic [3:0] code;
    logic [7:0] bval;
    logic       ack;
    logic       disturb;
    logic [7:0] exp_stat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'h1, 8'h00, 1'b0, 1'b0, 8'h31},
    '{4'h3, 8'hA5, 1'b1, 1'b0, 8'h13},
    '{4'h3, 8'h3C, 1'b0, 1'b0, 8'h33},
    '{4'h4, 8'h96, 1'b0, 1'b0, 8'h24},
    '{4'h5, 8'h5A, 1'b0, 1'b0, 8'h35},
    '{4'h2, 8'h00, 1'b0, 1'b0, 8'h32},
    '{4'h0, 8'h00, 1'b0, 1'b0, 8'hB2},
    '{4'hF, 8'h00, 1'b0, 1'b0, 8'hB2},
    '{4'h3, 8'h01, 1'b1, 1'b0, 8'h13},
    '{4'h3, 8'h6B, 1'b1, 1'b1, 8'h93}
  };

  logic       clk, rst, wr_data, wr_ctrl, irq, scl, sda_oe, sda_in;
  logic [7:0] wdata, data_q, stat_q;
  logic       slv_low;
  wire        sda_line = !(sda_oe || slv_low);
  assign sda_in = sda_line;

  serial_prom_master #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ)) uut (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .wdata(wdata), .data_q(data_q), .stat_q(stat_q), .scl(scl),
    .sda_oe(sda_oe), .sda_in(sda_in), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0, done_flag = 0;
  int mode = 0, fall_n = 0, rise_n = 0, starts = 0, stops = 0, viol = 0, irq_cnt = 0;
  logic       slave_ack = 1'b0, in_byte = 1'b0, mack = 1'b0;
  logic [7:0] slave_byte = 8'h00, cap = 8'h00;
  longint     t_r1 = 0, t_r2 = 0;

  initial slv_low = 1'b0;

  always @(negedge scl) begin
    fall_n = fall_n + 1;
    if (mode == 1) begin
      if (fall_n == 9) slv_low = slave_ack;
      if (fall_n == 10) slv_low = 1'b0;
    end else if (mode == 2) begin
      if (fall_n <= 8) slv_low = ~slave_byte[8 - fall_n];
      else slv_low = 1'b0;
    end
  end

  always @(posedge scl) begin
    rise_n = rise_n + 1;
    if (rise_n == 1) t_r1 = $time;
    if (rise_n == 2) t_r2 = $time;
    if (mode == 1 && rise_n <= 8) cap = {cap[6:0], sda_line};
    if (rise_n == 9) mack = sda_line;
  end

  always @(negedge sda_line) if (scl === 1'b1) begin
    starts = starts + 1;
    if (in_byte) viol = viol + 1;
  end
  always @(posedge sda_line) if (scl === 1'b1) begin
    stops = stops + 1;
    if (in_byte) viol = viol + 1;
  end

  always @(posedge clk) if (!rst && irq === 1'b1) irq_cnt <= irq_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (done_flag == 0) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic write_reg(input logic is_ctrl, input logic [7:0] v);
    @(negedge clk);
    wdata = v;
    if (is_ctrl) wr_ctrl = 1'b1; else wr_data = 1'b1;
    @(negedge clk);
    wr_ctrl = 1'b0;
    wr_data = 1'b0;
  endtask

  task automatic run_op(input vec_t v, input int idx);
    logic legal;
    int s0, p0, i0, n;
    legal = (v.code >= 4'h1) && (v.code <= 4'h5);
    mode = (v.code == 4'h3) ? 1 : ((v.code == 4'h4 || v.code == 4'h5) ? 2 : 0);
    slave_byte = v.bval;
    slave_ack = v.ack;
    fall_n = 0; rise_n = 0; cap = 8'h00; viol = 0;
    s0 = starts; p0 = stops; i0 = irq_cnt;
    if (v.code == 4'h3) write_reg(1'b0, v.bval);
    in_byte = (mode != 0);
    write_reg(1'b1, {4'h0, v.code});
    check($sformatf("R6 busy after command, vector %0d", idx), 32'(stat_q[6]), 32'(legal));
    if (v.disturb) begin
      repeat (20) @(negedge clk);
      write_reg(1'b1, 8'h04);
      write_reg(1'b0, 8'hFF);
    end
    n = 0;
    while (stat_q[6] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check($sformatf("R6 scl high when idle, vector %0d", idx), 32'(scl), 32'd1);
    repeat (3) @(negedge clk);
    in_byte = 1'b0;
    check($sformatf("R8 status word, vector %0d", idx), 32'(stat_q), 32'(v.exp_stat));
    check($sformatf("R7 irq pulses, vector %0d", idx), 32'(irq_cnt - i0), 32'(legal));
    if (mode == 1) begin
      check($sformatf("R2 byte on wire MSB first, vector %0d", idx), 32'(cap), 32'(v.bval));
      check($sformatf("R2 sda stable while scl high, vector %0d", idx), 32'(viol), 32'd0);
      check($sformatf("R2 data register kept, vector %0d", idx), 32'(data_q), 32'(v.bval));
      check($sformatf("R3 ack status bit, vector %0d", idx), 32'(stat_q[5]), 32'(!v.ack));
      if (idx == 1)
        check("R10 scl period in cycles", 32'((t_r2 - t_r1) / CLK_PERIOD), 32'(BIT_CYC));
      if (v.disturb) begin
        check("R9 error after busy command", 32'(stat_q[7]), 32'd1);
        check("R9 data write ignored while busy", 32'(data_q), 32'(v.bval));
      end
    end else if (mode == 2) begin
      check($sformatf("R4 received byte, vector %0d", idx), 32'(data_q), 32'(v.bval));
      check($sformatf("R4 host ack level, vector %0d", idx), 32'(mack), 32'(v.code == 4'h5));
      check($sformatf("R2 sda stable while scl high, vector %0d", idx), 32'(viol), 32'd0);
    end else if (v.code == 4'h1) begin
      check("R5 start condition seen", 32'(starts - s0), 32'd1);
    end else if (v.code == 4'h2) begin
      check("R5 stop condition seen", 32'(stops - p0), 32'd1);
    end else begin
      check($sformatf("R8 no bus activity, vector %0d", idx), 32'(fall_n), 32'd0);
    end
    mode = 0;
  endtask

  task automatic check_reset_state(input string tag);
    check({"R1 status ", tag}, 32'(stat_q), 32'h30);
    check({"R1 data ", tag}, 32'(data_q), 32'h00);
    check({"R1 scl/sda_oe/irq ", tag}, {29'd0, scl, sda_oe, irq}, 32'b100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst = 1'b1; wr_data = 1'b0; wr_ctrl = 1'b0; wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("after power-up");

    for (int i = 0; i < NV; i++) run_op(VECS[i], i);

    // R1: reset in the middle of a transmit
    mode = 1; slave_ack = 1'b1; fall_n = 0; rise_n = 0;
    write_reg(1'b0, 8'hC3);
    write_reg(1'b1, 8'h03);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    mode = 0; slv_low = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("after mid-transfer reset");

    finish_up();
  end
endmodule